// File: doc/BRIEF.md
# Multi-CPU Interrupt Level Controller

This block gathers thirty-two system interrupt lines into one global pending word and turns them into a 4-bit processor interrupt level for each CPU. Software controls a global mask through two write-only views: writing ones to one view masks the selected sources, and writing ones to the other view unmasks them. Bit 31 of the mask is a master switch. While it is set, every global source is blocked.

Four asynchronous error sources are sent to every CPU at level 15. All other global sources are undirected and go only to the CPU named in a target register. Each CPU also has its own soft-interrupt word. Any bus master can raise or drop bits in it, so it serves for signalling between processors. Each CPU has a private timer input that feeds level 14.

Each CPU's output level is the highest level among everything that currently reaches that CPU. It is registered once. All registers sit on a word-addressed bus with a single-cycle write strobe and a combinational read.

Top module: `irq_level_ctrl`

## Requirements
- R1: After reset the global mask reads 0xFFFF_FFFF, the target register reads 0, every per-CPU soft word reads 0 and every level output is 0.
- R2: Word address 4*NUM_CPU+1 reads the mask. Writing ones to address 4*NUM_CPU+3 sets those mask bits. Writing ones to 4*NUM_CPU+2 clears them. Zero bits leave the mask unchanged, and a masked source adds no level.
- R3: While mask bit 31 is set, no global source, including the error sources, adds to any CPU's level.
- R4: Address 4*NUM_CPU+0 returns the global source lines as sampled on the previous clock edge. Writes to that address are ignored.
- R5: The onboard sources map to fixed levels: bit 18 to 4, bit 16 to 6, bit 20 to 8, bit 21 to 9, bit 19 to 10, bit 22 to 11, bits 15 and 14 to 12, and bit 17 to 13. Bits 26 to 23 and bit 31 have no level.
- R6: Expansion-bus levels 1 to 7 appear on bits 7 to 13 and on bits 0 to 6. Their levels are 2, 3, 5, 7, 9, 11 and 13, in that order.
- R7: An unmasked source on any of bits 30 to 27 drives every CPU's level to 15, whatever the target register holds.
- R8: Address 4*NUM_CPU+4 holds the target CPU number. Unmasked non-error global sources count only for that CPU.
- R9: For CPU c, the soft word reads at address 4c. Writing ones to 4c+2 sets bits and writing ones to 4c+1 clears them. Soft bit 16+n (n = 1 to 15) gives level n on CPU c only. Bit 16 and the low bits cannot be set, and zero bits change nothing.
- R10: While CPU c's timer input is high, bit 7 of CPU c's soft word reads 1 and CPU c's level is at least 14.
- R11: CPU c's output on pil_o[4c+3:4c] is the highest level among its soft bits, its timer and the global sources that reach it. It is 0 when nothing reaches it.
- R12: A change on a source or timer input reaches the level output on the second rising edge. A register write reaches it on the first edge after the write edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_i | input | 32 | Global interrupt source lines, active high |
| cpu_timer_i | input | NUM_CPU | Per-CPU timer request lines |
| bus_wr | input | 1 | Write strobe for the addressed word |
| bus_addr | input | ADDR_W | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| pil_o | output | 4*NUM_CPU | Interrupt level per CPU, CPU c at bits 4c+3:4c |

## Verification
A wrong mask, target or soft-word bit would first show at the ports as a wrong level on one CPU's slice of pil_o. That error appears exactly one edge after the register changes, and it can also be read back on the next bus read. A routing fault, such as an undirected source reaching a CPU that is not the target or an error source missing from one CPU, shows as a nonzero or non-15 slice in the same cycle as the correct slices. The checks therefore compare every CPU's slice after each stimulus, not only the slice of the CPU being tested.

// File: rtl/ilc_pkg.sv
package ilc_pkg;
    localparam int WORD_W     = 32;
    localparam int LVL_W      = 4;
    localparam int MASTER_BIT = 31;
    localparam int ERR_LO     = 27;
    localparam int ERR_HI     = 30;
    localparam int TIMER_BIT  = 7;
    localparam int SOFT_BASE  = 16;
    localparam logic [WORD_W-1:0] ERR_BITS =
        ((WORD_W'(1) << (ERR_HI - ERR_LO + 1)) - WORD_W'(1)) << ERR_LO;

    typedef logic [LVL_W-1:0] lvl_t;

    typedef enum logic [3:0] {
        ACC_NONE,
        ACC_GPEND,
        ACC_GMASK,
        ACC_GUNMASK,
        ACC_GMASKSET,
        ACC_GTARGET,
        ACC_CPEND,
        ACC_CCLR,
        ACC_CSET
    } acc_kind_e;

    function automatic lvl_t bus_level(input int k);
        lvl_t r;
        case (k)
            1:       r = 4'd2;
            2:       r = 4'd3;
            3:       r = 4'd5;
            4:       r = 4'd7;
            5:       r = 4'd9;
            6:       r = 4'd11;
            7:       r = 4'd13;
            default: r = 4'd0;
        endcase
        return r;
    endfunction

    function automatic lvl_t global_level(input int b);
        lvl_t r;
        if (b >= ERR_LO && b <= ERR_HI) begin
            r = 4'd15;
        end else begin
            case (b)
                22:      r = 4'd11;
                21:      r = 4'd9;
                20:      r = 4'd8;
                19:      r = 4'd10;
                18:      r = 4'd4;
                17:      r = 4'd13;
                16:      r = 4'd6;
                15:      r = 4'd12;
                14:      r = 4'd12;
                default: begin
                    if (b >= 7 && b <= 13)
                        r = bus_level(b - 6);
                    else if (b >= 0 && b <= 6)
                        r = bus_level(b + 1);
                    else
                        r = 4'd0;
                end
            endcase
        end
        return r;
    endfunction

    function automatic lvl_t local_level(input int b);
        lvl_t r;
        if (b == TIMER_BIT)
            r = 4'd14;
        else if (b > SOFT_BASE)
            r = lvl_t'(b - SOFT_BASE);
        else
            r = 4'd0;
        return r;
    endfunction
endpackage

// File: rtl/ilc_global_regs.sv
module ilc_global_regs
    import ilc_pkg::*;
#(
    parameter int CPU_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] src_i,
    input  logic              mask_set_en,
    input  logic              mask_clr_en,
    input  logic              tgt_wr_en,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] pend_q,
    output logic [WORD_W-1:0] mask_q,
    output logic [CPU_W-1:0]  tgt_q
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= '0;
            mask_q <= '1;
            tgt_q  <= '0;
        end else begin
            pend_q <= src_i;
            if (mask_set_en)
                mask_q <= mask_q | wdata;
            else if (mask_clr_en)
                mask_q <= mask_q & ~wdata;
            if (tgt_wr_en)
                tgt_q <= wdata[CPU_W-1:0];
        end
    end
endmodule

// File: rtl/ilc_cpu_soft.sv
module ilc_cpu_soft
    import ilc_pkg::*;
(
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           set_en,
    input  logic                           clr_en,
    input  logic [WORD_W-1:SOFT_BASE+1]    wbits,
    input  logic                           timer_i,
    output logic [WORD_W-1:0]              pend_o
);
    logic [WORD_W-1:SOFT_BASE+1] soft_q;
    logic                        timer_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            soft_q  <= '0;
            timer_q <= 1'b0;
        end else begin
            timer_q <= timer_i;
            if (set_en)
                soft_q <= soft_q | wbits;
            else if (clr_en)
                soft_q <= soft_q & ~wbits;
        end
    end

    always_comb begin
        pend_o                          = '0;
        pend_o[WORD_W-1:SOFT_BASE+1]    = soft_q;
        pend_o[TIMER_BIT]               = timer_q;
    end
endmodule

// File: rtl/ilc_level_pick.sv
module ilc_level_pick
    import ilc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] glob_i,
    input  logic [WORD_W-1:0] local_i,
    output lvl_t              lvl_q
);
    lvl_t best;

    always_comb begin
        best = '0;
        for (int b = 0; b < WORD_W; b++) begin
            if (glob_i[b] && global_level(b) > best)
                best = global_level(b);
            if (local_i[b] && local_level(b) > best)
                best = local_level(b);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            lvl_q <= '0;
        else
            lvl_q <= best;
    end
endmodule

// File: rtl/irq_level_ctrl.sv
module irq_level_ctrl
    import ilc_pkg::*;
#(
    parameter int NUM_CPU = 4,
    parameter int ADDR_W  = $clog2(4 * NUM_CPU + 8)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [31:0]              src_i,
    input  logic [NUM_CPU-1:0]       cpu_timer_i,
    input  logic                     bus_wr,
    input  logic [ADDR_W-1:0]        bus_addr,
    input  logic [31:0]              bus_wdata,
    output logic [31:0]              bus_rdata,
    output logic [4*NUM_CPU-1:0]     pil_o
);
    localparam int CPU_W  = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1;
    localparam int G_BASE = 4 * NUM_CPU;

    acc_kind_e           acc_kind;
    logic [CPU_W-1:0]    acc_cpu;
    logic [WORD_W-1:0]   g_pend;
    logic [WORD_W-1:0]   g_mask;
    logic [CPU_W-1:0]    g_tgt;
    logic [WORD_W-1:0]   g_live;
    logic [WORD_W-1:0]   cpu_pend [NUM_CPU];
    logic [NUM_CPU*WORD_W-1:0] cpu_pend_flat;
    logic [ADDR_W-1:0]   g_off;

    // Address decode: per-CPU words first, global words after them.
    assign g_off = bus_addr - ADDR_W'(G_BASE);

    always_comb begin
        acc_kind = ACC_NONE;
        acc_cpu  = CPU_W'(bus_addr >> 2);
        if (bus_addr < ADDR_W'(G_BASE)) begin
            case (bus_addr[1:0])
                2'd0:    acc_kind = ACC_CPEND;
                2'd1:    acc_kind = ACC_CCLR;
                2'd2:    acc_kind = ACC_CSET;
                default: acc_kind = ACC_NONE;
            endcase
        end else begin
            case (g_off)
                ADDR_W'(0): acc_kind = ACC_GPEND;
                ADDR_W'(1): acc_kind = ACC_GMASK;
                ADDR_W'(2): acc_kind = ACC_GUNMASK;
                ADDR_W'(3): acc_kind = ACC_GMASKSET;
                ADDR_W'(4): acc_kind = ACC_GTARGET;
                default:    acc_kind = ACC_NONE;
            endcase
        end
    end

    ilc_global_regs #(.CPU_W(CPU_W)) u_glob (
        .clk         (clk),
        .rst_n       (rst_n),
        .src_i       (src_i),
        .mask_set_en (bus_wr && acc_kind == ACC_GMASKSET),
        .mask_clr_en (bus_wr && acc_kind == ACC_GUNMASK),
        .tgt_wr_en   (bus_wr && acc_kind == ACC_GTARGET),
        .wdata       (bus_wdata),
        .pend_q      (g_pend),
        .mask_q      (g_mask),
        .tgt_q       (g_tgt)
    );

    // Unmasked global sources, all blocked by the master bit.
    assign g_live = g_mask[MASTER_BIT] ? '0 : (g_pend & ~g_mask);

    for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
        logic [WORD_W-1:0] reach;

        ilc_cpu_soft u_soft (
            .clk     (clk),
            .rst_n   (rst_n),
            .set_en  (bus_wr && acc_kind == ACC_CSET && acc_cpu == CPU_W'(c)),
            .clr_en  (bus_wr && acc_kind == ACC_CCLR && acc_cpu == CPU_W'(c)),
            .wbits   (bus_wdata[WORD_W-1:SOFT_BASE+1]),
            .timer_i (cpu_timer_i[c]),
            .pend_o  (cpu_pend[c])
        );

        assign reach = (g_live & ERR_BITS) |
                       ((g_tgt == CPU_W'(c)) ? (g_live & ~ERR_BITS) : '0);

        ilc_level_pick u_pick (
            .clk     (clk),
            .rst_n   (rst_n),
            .glob_i  (reach),
            .local_i (cpu_pend[c]),
            .lvl_q   (pil_o[4*c +: 4])
        );

        assign cpu_pend_flat[WORD_W*c +: WORD_W] = cpu_pend[c];
    end

    always_comb begin
        case (acc_kind)
            ACC_GPEND:   bus_rdata = g_pend;
            ACC_GMASK:   bus_rdata = g_mask;
            ACC_GTARGET: bus_rdata = {{(WORD_W-CPU_W){1'b0}}, g_tgt};
            ACC_CPEND:   bus_rdata = cpu_pend[acc_cpu];
            default:     bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/irq_level_ctrl_chk.sv
module irq_level_ctrl_chk
    import ilc_pkg::*;
#(
    parameter int NUM_CPU = 4,
    parameter int ADDR_W  = 5
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      bus_wr,
    input logic [ADDR_W-1:0]         bus_addr,
    input logic [31:0]               bus_wdata,
    input logic [4*NUM_CPU-1:0]      pil_o,
    input logic [31:0]               g_mask,
    input logic [31:0]               g_pend,
    input logic [NUM_CPU*32-1:0]     cpu_pend_flat
);
    localparam int G_BASE = 4 * NUM_CPU;
    localparam logic [ADDR_W-1:0] A_UNMASK = ADDR_W'(G_BASE + 2);
    localparam logic [ADDR_W-1:0] A_MASK   = ADDR_W'(G_BASE + 3);

    AST_MASK_SET_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == A_MASK) |=>
            ((g_mask & $past(bus_wdata)) == $past(bus_wdata))); // R2

    AST_UNMASK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == A_UNMASK) |=>
            ((g_mask & $past(bus_wdata)) == 32'h0)); // R2

    AST_ZERO_WRITE_KEEPS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && (bus_addr == A_MASK || bus_addr == A_UNMASK) && bus_wdata == 32'h0)
            |=> $stable(g_mask)); // R2

    AST_MASTER_SILENCES: assert property (@(posedge clk) disable iff (!rst_n)
        (g_mask[31] && cpu_pend_flat == '0) |=> (pil_o == '0)); // R3

    AST_ERROR_BROADCAST: assert property (@(posedge clk) disable iff (!rst_n)
        (!g_mask[31] && (g_pend & ~g_mask & ERR_BITS) != 32'h0)
            |=> (pil_o == {NUM_CPU{4'hF}})); // R7
endmodule

bind irq_level_ctrl irq_level_ctrl_chk #(.NUM_CPU(NUM_CPU), .ADDR_W(ADDR_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .bus_wr        (bus_wr),
    .bus_addr      (bus_addr),
    .bus_wdata     (bus_wdata),
    .pil_o         (pil_o),
    .g_mask        (g_mask),
    .g_pend        (g_pend),
    .cpu_pend_flat (cpu_pend_flat)
);

// File: tb/irq_level_ctrl_tb.sv
module irq_level_ctrl_tb;
    localparam int NCPU = 4;
    localparam int AW   = 5;
    localparam int G    = 4 * NCPU;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [31:0]     src_i = '0;
    logic [NCPU-1:0] cpu_timer_i = '0;
    logic            bus_wr = 1'b0;
    logic [AW-1:0]   bus_addr = '0;
    logic [31:0]     bus_wdata = '0;
    logic [31:0]     bus_rdata;
    logic [4*NCPU-1:0] pil_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2 clk = ~clk;

    irq_level_ctrl #(.NUM_CPU(NCPU), .ADDR_W(AW)) u_dut (
        .clk(clk), .rst_n(rst_n), .src_i(src_i), .cpu_timer_i(cpu_timer_i),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .pil_o(pil_o)
    );

    function automatic logic [3:0] exp_level(input int b);
        case (b)
            30, 29, 28, 27: return 4'd15;
            22: return 4'd11;  21: return 4'd9;   20: return 4'd8;
            19: return 4'd10;  18: return 4'd4;   17: return 4'd13;
            16: return 4'd6;   15: return 4'd12;  14: return 4'd12;
            13: return 4'd13;  12: return 4'd11;  11: return 4'd9;
            10: return 4'd7;   9:  return 4'd5;   8:  return 4'd3;
            7:  return 4'd2;
            6:  return 4'd13;  5:  return 4'd11;  4:  return 4'd9;
            3:  return 4'd7;   2:  return 4'd5;   1:  return 4'd3;
            0:  return 4'd2;
            default: return 4'd0;
        endcase
    endfunction

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
        end
    endtask

    task automatic cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = AW'(a); bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(input int a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = AW'(a);
        #1 d = bus_rdata;
    endtask

    function automatic logic [3:0] pil(input int c);
        return pil_o[4*c +: 4];
    endfunction

    task automatic chk_all(input string req, input logic [3:0] e0, input logic [3:0] e1,
                           input logic [3:0] e2, input logic [3:0] e3);
        chk(req, "cpu0 level", 32'(pil(0)), 32'(e0));
        chk(req, "cpu1 level", 32'(pil(1)), 32'(e1));
        chk(req, "cpu2 level", 32'(pil(2)), 32'(e2));
        chk(req, "cpu3 level", 32'(pil(3)), 32'(e3));
    endtask

    task automatic t_reset;
        logic [31:0] d;
        rd(G + 1, d); chk("R1", "mask after reset", d, 32'hFFFF_FFFF);
        rd(G + 4, d); chk("R1", "target after reset", d, 32'h0);
        for (int c = 0; c < NCPU; c++) begin
            rd(4 * c, d); chk("R1", "soft after reset", d, 32'h0);
        end
        chk_all("R1", 0, 0, 0, 0);
    endtask

    task automatic t_mask;
        logic [31:0] d;
        wr(G + 2, 32'h0000_00FF); rd(G + 1, d); chk("R2", "unmask low byte", d, 32'hFFFF_FF00);
        wr(G + 3, 32'h0000_000F); rd(G + 1, d); chk("R2", "mask nibble", d, 32'hFFFF_FF0F);
        wr(G + 3, 32'h0);          rd(G + 1, d); chk("R2", "zero set write", d, 32'hFFFF_FF0F);
        wr(G + 2, 32'h0);          rd(G + 1, d); chk("R2", "zero clear write", d, 32'hFFFF_FF0F);
        wr(G + 2, 32'hFFFF_FFFF); rd(G + 1, d); chk("R2", "unmask all", d, 32'h0);
        wr(G + 3, 32'h0004_0000); src_i = 32'h0004_0000; cycles(3);
        chk_all("R2", 0, 0, 0, 0);
        wr(G + 2, 32'h0004_0000); cycles(2);
        chk_all("R2", 4, 0, 0, 0);
        src_i = '0; cycles(3);
    endtask

    task automatic t_pending;
        logic [31:0] d;
        src_i = 32'hA5C3_0F18; cycles(2);
        wr(G, 32'hFFFF_FFFF);
        rd(G, d); chk("R4", "global pending", d, 32'hA5C3_0F18);
        src_i = '0; cycles(3);
        rd(G, d); chk("R4", "global pending cleared", d, 32'h0);
    endtask

    task automatic t_map(input int lo, input int hi, input string req);
        for (int b = lo; b <= hi; b++) begin
            src_i = 32'h1 << b; cycles(3);
            if (exp_level(b) == 4'd15)
                chk_all(req, 15, 15, 15, 15);
            else
                chk_all(req, exp_level(b), 0, 0, 0);
        end
        src_i = '0; cycles(3);
    endtask

    task automatic t_target;
        logic [31:0] d;
        wr(G + 4, 32'h2); rd(G + 4, d); chk("R8", "target readback", d, 32'h2);
        src_i = 32'h0004_0000; cycles(3);
        chk_all("R8", 0, 0, 4, 0);
        src_i = 32'h1000_0000; cycles(3);
        chk_all("R7", 15, 15, 15, 15);
        src_i = '0; wr(G + 4, 32'h0); cycles(3);
    endtask

    task automatic t_master;
        wr(G + 3, 32'h8000_0000);
        src_i = 32'h2004_0080; cycles(3);
        chk_all("R3", 0, 0, 0, 0);
        wr(G + 2, 32'h8000_0000); cycles(2);
        chk_all("R3", 15, 15, 15, 15);
        src_i = '0; cycles(3);
    endtask

    task automatic t_soft;
        logic [31:0] d;
        wr(6, 32'h0020_0000); cycles(1);
        chk_all("R9", 0, 5, 0, 0);
        rd(4, d); chk("R9", "cpu1 soft word", d, 32'h0020_0000);
        rd(0, d); chk("R9", "cpu0 soft untouched", d, 32'h0);
        wr(6, 32'h0);          rd(4, d); chk("R9", "zero set write", d, 32'h0020_0000);
        wr(6, 32'h0001_FFFF);  rd(4, d); chk("R9", "bit16 and low bits ignored", d, 32'h0020_0000);
        wr(5, 32'h0020_0000); cycles(1);
        rd(4, d); chk("R9", "cpu1 soft cleared", d, 32'h0);
        chk_all("R9", 0, 0, 0, 0);
        wr(14, 32'h8000_0000); cycles(1);
        chk_all("R9", 0, 0, 0, 15);
        wr(13, 32'hFFFF_FFFF); cycles(1);
    endtask

    task automatic t_timer;
        logic [31:0] d;
        cpu_timer_i = 4'b1000; cycles(3);
        chk_all("R10", 0, 0, 0, 14);
        rd(12, d); chk("R10", "cpu3 timer bit", d, 32'h0000_0080);
        cpu_timer_i = '0; cycles(3);
        chk_all("R10", 0, 0, 0, 0);
    endtask

    task automatic t_priority;
        wr(2, 32'h0208_0000); src_i = 32'h0004_0000; cycles(3);
        chk("R11", "highest of soft 3, soft 9, scsi 4", 32'(pil(0)), 32'd9);
        wr(1, 32'h0200_0000); cycles(1);
        chk("R11", "after dropping soft 9", 32'(pil(0)), 32'd4);
        cpu_timer_i = 4'b0001; cycles(3);
        chk("R11", "timer above all", 32'(pil(0)), 32'd14);
        cpu_timer_i = '0; src_i = '0; wr(1, 32'hFFFF_FFFF); cycles(3);
        chk_all("R11", 0, 0, 0, 0);
    endtask

    task automatic t_latency;
        @(negedge clk); src_i = 32'h0008_0000;
        @(negedge clk);
        chk("R12", "level one edge after source", 32'(pil(0)), 32'd0);
        @(negedge clk);
        chk("R12", "level two edges after source", 32'(pil(0)), 32'd10);
        src_i = '0; cycles(3);
        @(negedge clk); bus_wr = 1'b1; bus_addr = AW'(2); bus_wdata = 32'h0004_0000;
        @(negedge clk); bus_wr = 1'b0; bus_wdata = '0;
        chk("R12", "level at write edge", 32'(pil(0)), 32'd0);
        @(negedge clk);
        chk("R12", "level one edge after write", 32'(pil(0)), 32'd2);
        wr(1, 32'hFFFF_FFFF); cycles(2);
    endtask

    task automatic finish_run;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        cycles(3);
        rst_n = 1'b1;
        cycles(1);
        t_reset;
        t_mask;
        t_pending;
        t_map(14, 22, "R5");
        t_map(23, 26, "R5");
        t_map(31, 31, "R5");
        t_map(0, 13, "R6");
        t_map(27, 30, "R7");
        t_target;
        t_master;
        t_soft;
        t_timer;
        t_priority;
        t_latency;
        done = 1;
        finish_run;
    end

    initial begin
        #(4 * 100000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run;
        end
    end
endmodule